// File: doc/BRIEF.md
# Ones'-Complement Add/Subtract Unit

This unit adds or subtracts two signed words held in ones'-complement form. In that form a negative value is the bitwise inverse of its positive counterpart. The top bit gives the sign, but the remaining bits are not a plain magnitude. Subtraction inverts the second operand and then uses the same adder as addition.

The adder's carry out of the top bit is not discarded. It is fed back and added into the least significant bit in a second, fold-back step. Both all-zeros and all-ones stand for zero, so the zero flag accepts either pattern. A signed-overflow flag reports when the true result cannot be held in the word.

By default the result and both flags are captured in output registers on a cycle where the capture strobe is high. They hold their value otherwise. A parameter selects a purely combinational variant instead.

Top module: `oc_addsub`

## Requirements
- R1: With op = 0, the result is a + b computed modulo 2^WIDTH. When that sum carries out of the top bit, one is added to the low bits, so 0xFFFF + 0x0001 gives 0x0001 and 0xFFFE + 0xFFFE gives 0xFFFD at WIDTH = 16.
- R2: With op = 1, the result is a plus the bitwise inverse of b, with the same fold-back of the carry. For example, 5 - 3 gives 0x0002 and 3 - 5 gives 0xFFFD at WIDTH = 16.
- R3: The fold-back step never produces a carry of its own out of the top bit, so a single fold is always enough.
- R4: The overflow flag is 1 exactly when the two adder inputs (a and the possibly inverted b) share a top bit and the result's top bit differs from it.
- R5: The zero flag is 1 exactly when the result is all zeros or all ones.
- R6: With REGISTERED = 1, the outputs take the new values on the rising clock edge where valid_in is 1. On an edge where valid_in is 0, result and both flags keep their previous values whatever a, b and op do.
- R7: While rst_n is 0 (asynchronous, active low), result reads all zeros, overflow reads 0 and zero reads 1.
- R8: The op input is encoded as 0 for add and 1 for subtract, and the same datapath serves both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_in | input | 1 | Capture strobe for the output registers |
| op | input | 1 | 0 = add, 1 = subtract |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand (subtrahend when op = 1) |
| result | output | WIDTH | Ones'-complement sum or difference |
| overflow | output | 1 | Signed overflow of the operation |
| zero | output | 1 | Result encodes zero (all zeros or all ones) |

## Verification
The assertions watch four properties on every clock cycle:
- the fold-back step never carries out;
- the registered outputs stay frozen on idle cycles;
- the zero flag always agrees with the held result;
- overflow cannot appear on a capture whose adder inputs had different sign bits.

Whether the folded sum is numerically correct can only be shown by the bench's scenarios, which compare against hand-computed values. These scenarios cover the carry-rippling fold of 0xFFFF + 0x0001, both encodings of zero, overflow at each end of the range, and subtraction that crosses zero in each direction.

// File: rtl/oc_pkg.sv
package oc_pkg;
    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } oc_op_e;
endpackage

// File: rtl/oc_operand_prep.sv
module oc_operand_prep #(
    parameter int WIDTH = 16
) (
    input  oc_pkg::oc_op_e   op,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_out
);
    // R8: subtract presents the inverted subtrahend to the shared adder
    always_comb begin
        unique case (op)
            oc_pkg::OP_ADD: b_out = b_in;
            oc_pkg::OP_SUB: b_out = ~b_in;
            default:        b_out = b_in;
        endcase
    end
endmodule

// File: rtl/oc_eac_adder.sv
module oc_eac_adder #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    output logic [WIDTH-1:0] sum
);
    localparam int EXT = WIDTH + 1;

    logic [EXT-1:0] main_sum;
    logic [EXT-1:0] fold_sum;
    logic           fold_carry;

    // R1, R2: main addition, then the top carry is folded into bit 0
    always_comb begin
        main_sum   = {1'b0, x} + {1'b0, y};
        fold_sum   = {1'b0, main_sum[WIDTH-1:0]} + EXT'(main_sum[WIDTH]);
        fold_carry = fold_sum[WIDTH];
        sum        = fold_sum[WIDTH-1:0];
    end

    AST_SINGLE_FOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !fold_carry); // R3
endmodule

// File: rtl/oc_flag_gen.sv
module oc_flag_gen #(
    parameter int WIDTH = 16
) (
    input  logic             x_msb,
    input  logic             y_msb,
    input  logic [WIDTH-1:0] sum,
    output logic             ovf,
    output logic             is_zero
);
    // R4: same-sign inputs with a different-sign result
    // R5: both encodings of zero are accepted
    always_comb begin
        ovf     = (x_msb == y_msb) && (sum[WIDTH-1] != x_msb);
        is_zero = (sum == '0) || (sum == '1);
    end
endmodule

// File: rtl/oc_addsub.sv
module oc_addsub #(
    parameter int WIDTH      = 16,
    parameter bit REGISTERED = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_in,
    input  logic             op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    output logic [WIDTH-1:0] result,
    output logic             overflow,
    output logic             zero
);
    oc_pkg::oc_op_e   op_e;
    logic [WIDTH-1:0] b_eff;
    logic [WIDTH-1:0] sum_c;
    logic             ovf_c;
    logic             zero_c;

    assign op_e = oc_pkg::oc_op_e'(op);

    oc_operand_prep #(.WIDTH(WIDTH)) u_prep (
        .op   (op_e),
        .b_in (b),
        .b_out(b_eff)
    );

    oc_eac_adder #(.WIDTH(WIDTH)) u_add (
        .clk  (clk),
        .rst_n(rst_n),
        .x    (a),
        .y    (b_eff),
        .sum  (sum_c)
    );

    oc_flag_gen #(.WIDTH(WIDTH)) u_flags (
        .x_msb  (a[WIDTH-1]),
        .y_msb  (b_eff[WIDTH-1]),
        .sum    (sum_c),
        .ovf    (ovf_c),
        .is_zero(zero_c)
    );

    generate
        if (REGISTERED) begin : g_reg
            logic [WIDTH-1:0] result_q;
            logic             ovf_q;
            logic             zero_q;

            // R6, R7: capture on strobe, hold otherwise, async reset
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    result_q <= '0;
                    ovf_q    <= 1'b0;
                    zero_q   <= 1'b1;
                end else if (valid_in) begin
                    result_q <= sum_c;
                    ovf_q    <= ovf_c;
                    zero_q   <= zero_c;
                end
            end

            assign result   = result_q;
            assign overflow = ovf_q;
            assign zero     = zero_q;

            AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
                !valid_in |=> ($stable(result_q) && $stable(ovf_q) && $stable(zero_q))); // R6
            AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
                zero_q == ((result_q == '0) || (result_q == '1))); // R5
            AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
                (valid_in && (a[WIDTH-1] != b_eff[WIDTH-1])) |=> !ovf_q); // R4
        end else begin : g_comb
            assign result   = sum_c;
            assign overflow = ovf_c;
            assign zero     = zero_c;
        end
    endgenerate
endmodule

// File: tb/test_oc_addsub.sv
module test_oc_addsub;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 16;
    localparam int NVEC       = 13;

    // {op, a, b, result, overflow, zero}
    localparam logic [50:0] VEC [NVEC] = '{
        {1'b0, 16'h0003, 16'h0004, 16'h0007, 1'b0, 1'b0}, // R1 plain add
        {1'b1, 16'h0005, 16'h0003, 16'h0002, 1'b0, 1'b0}, // R2 carry folded
        {1'b1, 16'h0003, 16'h0005, 16'hFFFD, 1'b0, 1'b0}, // R2 negative result
        {1'b0, 16'h0005, 16'hFFFA, 16'hFFFF, 1'b0, 1'b1}, // R5 all-ones zero
        {1'b1, 16'h0007, 16'h0007, 16'hFFFF, 1'b0, 1'b1}, // R8 sub to zero
        {1'b0, 16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b0, 1'b1}, // R3 fold of -0 + -0
        {1'b0, 16'h0000, 16'h0000, 16'h0000, 1'b0, 1'b1}, // R5 all-zeros zero
        {1'b0, 16'h7FFF, 16'h0001, 16'h8000, 1'b1, 1'b0}, // R4 positive overflow
        {1'b1, 16'h8000, 16'h0001, 16'h7FFF, 1'b1, 1'b0}, // R4 negative overflow
        {1'b0, 16'hFFFE, 16'hFFFE, 16'hFFFD, 1'b0, 1'b0}, // R1 -1 + -1
        {1'b0, 16'hFFFF, 16'h0001, 16'h0001, 1'b0, 1'b0}, // R3 rippling fold
        {1'b1, 16'h0000, 16'h0000, 16'hFFFF, 1'b0, 1'b1}, // R2 0 - 0
        {1'b0, 16'h1234, 16'h4321, 16'h5555, 1'b0, 1'b0}  // R1 mixed bits
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         valid_in = 1'b0;
    logic         op = 1'b0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic [W-1:0] result;
    logic         overflow;
    logic         zero;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    oc_addsub #(.WIDTH(W), .REGISTERED(1'b1)) i_oc_addsub (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .op(op),
        .a(a), .b(b), .result(result), .overflow(overflow), .zero(zero)
    );

    task automatic check(input string req, input logic [W-1:0] er,
                         input logic eo, input logic ez);
        checks++;
        if (result !== er || overflow !== eo || zero !== ez) begin
            errors++;
            $display("FAIL %s: got result=%h ovf=%b zero=%b expected result=%h ovf=%b zero=%b",
                     req, result, overflow, zero, er, eo, ez);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 3);
        check("R7 reset", 16'h0000, 1'b0, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 after release", 16'h0000, 1'b0, 1'b1);

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            op = VEC[i][50]; a = VEC[i][49:34]; b = VEC[i][33:18];
            valid_in = 1'b1;
            @(negedge clk);
            valid_in = 1'b0;
            check($sformatf("R1/R2 vector %0d", i), VEC[i][17:2], VEC[i][1], VEC[i][0]);
        end

        // R6: idle strobe, new operands must not disturb held outputs
        op = 1'b0; a = 16'h7FFF; b = 16'h0001;
        @(negedge clk);
        @(negedge clk);
        check("R6 hold", 16'h5555, 1'b0, 1'b0);

        // R6: strobe again captures the pending operands
        valid_in = 1'b1;
        @(negedge clk);
        valid_in = 1'b0;
        check("R6 capture", 16'h8000, 1'b1, 1'b0);

        // R7: asynchronous reset mid-run
        #(CLK_PERIOD/4);
        rst_n = 1'b0;
        #(CLK_PERIOD/8);
        check("R7 async", 16'h0000, 1'b0, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule